// File: doc/BRIEF.md
# Display Controller Command Parser

This block sits behind a byte-wide serial receiver in a small graphics display controller. Each incoming byte arrives with a select flag. When the flag marks a pixel-data byte, the byte is forwarded unchanged to the display RAM write port. When the flag marks a command byte, the block assembles an instruction. The instruction is an opcode followed by the number of argument bytes that the opcode needs.

Once an instruction is complete, the parser issues single-cycle load pulses. One pulse sets the column window, one sets the row window, and one updates the address remapping register. Every other recognised instruction is consumed silently, and its arguments are discarded. An opcode outside the known set raises a one-cycle error pulse and is treated as having no arguments. Argument bytes are held in a small buffer until the instruction completes. The argument counter then returns to zero, so the next command byte is read as a new opcode.

Top module: `oled_cmd_parser`

## Requirements
- R1: A byte with `in_valid`=1 and `in_is_data`=1 produces `ram_we`=1 and `ram_wdata` equal to that byte on the clock after it is taken. No command pulse occurs in that cycle. `ram_wdata` holds its value when there is no write.
- R2: While `rst` is high and after it falls, every output is 0 and the next command byte is interpreted as an opcode.
- R3: Opcode 0x15 takes two arguments. The cycle after the second one, `col_load` pulses for one cycle with `win_first` equal to the first argument and `win_last` equal to the second. `win_first` and `win_last` hold their values between loads.
- R4: Opcode 0x75 takes two arguments. The cycle after the second one, `row_load` pulses for one cycle, with the window values placed on `win_first` and `win_last` the same way as in R3.
- R5: Opcode 0xA0 takes one argument. The cycle after it, `remap_load` pulses and `remap_val` takes that argument. `remap_val` holds its value at all other times.
- R6: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each consume exactly one argument byte and produce no pulse. The byte after that argument is read as an opcode.
- R7: Opcode 0xB8 consumes exactly eight argument bytes and produces no pulse, whatever values those bytes carry.
- R8: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF, 0xE3 and 0xFF take no arguments and produce no pulse. The next command byte is read as an opcode.
- R9: Any other opcode produces a one-cycle `unknown_cmd` pulse on the next clock and takes no arguments.
- R10: Data bytes that arrive while an instruction is partly collected do not disturb it. Command collection continues where it left off when command bytes resume.
- R11: A cycle with `in_valid`=0 changes no state, and the next cycle carries no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_is_data | input | 1 | 1 = pixel data byte, 0 = command byte |
| in_byte | input | 8 | Incoming byte |
| ram_we | output | 1 | Display RAM write strobe |
| ram_wdata | output | 8 | Display RAM write data |
| col_load | output | 1 | Column window load pulse |
| row_load | output | 1 | Row window load pulse |
| win_first | output | 8 | Window start value for a load |
| win_last | output | 8 | Window end value for a load |
| remap_load | output | 1 | Remap register update pulse |
| remap_val | output | 8 | Current remap register value |
| unknown_cmd | output | 1 | Unrecognised opcode pulse |

## Verification
The bench builds the parser with `MAX_ARGS` at its default of 8. That is the smallest value that can hold the longest instruction, so the eight-argument greyscale load drives the counter and the buffer index to their top values. Directed sequences place opcode values inside argument positions and insert data bytes and idle cycles in the middle of instructions. A long random stream then mixes every opcode class with data.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_COL   = 2'd1,
    ACT_ROW   = 2'd2,
    ACT_REMAP = 2'd3
  } cmd_act_e;

  localparam logic [7:0] OP_COLWIN = 8'h15;
  localparam logic [7:0] OP_ROWWIN = 8'h75;
  localparam logic [7:0] OP_REMAP  = 8'hA0;
  localparam logic [7:0] OP_GREY   = 8'hB8;
  localparam logic [7:0] OP_FILL   = 8'hFF;
endpackage

// File: rtl/ocp_lookup.sv
module ocp_lookup
  import oled_cmd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [BYTE_W-1:0] opcode,
  output logic [CNT_W-1:0]  nargs,
  output cmd_act_e          act,
  output logic              known
);
  always_comb begin
    nargs = '0;
    act   = ACT_NONE;
    known = 1'b1;
    unique case (opcode)
      OP_COLWIN: begin nargs = CNT_W'(2); act = ACT_COL; end
      OP_ROWWIN: begin nargs = CNT_W'(2); act = ACT_ROW; end
      OP_REMAP:  begin nargs = CNT_W'(1); act = ACT_REMAP; end
      OP_GREY:   nargs = CNT_W'(8);
      8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
        nargs = CNT_W'(1);
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, OP_FILL:
        nargs = '0;
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ocp_argbuf.sv
module ocp_argbuf
  import oled_cmd_pkg::*;
#(
  parameter int MAX_ARGS = 8,
  localparam int IDX_W = (MAX_ARGS > 1) ? $clog2(MAX_ARGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] slot_q [MAX_ARGS];

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/oled_cmd_parser.sv
module oled_cmd_parser
  import oled_cmd_pkg::*;
#(
  parameter int MAX_ARGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_is_data,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              col_load,
  output logic              row_load,
  output logic [BYTE_W-1:0] win_first,
  output logic [BYTE_W-1:0] win_last,
  output logic              remap_load,
  output logic [BYTE_W-1:0] remap_val,
  output logic              unknown_cmd
);
  localparam int CNT_W = $clog2(MAX_ARGS + 1);
  localparam int IDX_W = (MAX_ARGS > 1) ? $clog2(MAX_ARGS) : 1;

  logic [CNT_W-1:0]  cnt_q, need_q, lut_n;
  cmd_act_e          act_q, lut_act;
  logic              lut_known;
  logic [BYTE_W-1:0] arg0;

  wire cmd_byte = in_valid && !in_is_data;
  wire at_op    = (cnt_q == '0);
  wire arg_last = !at_op && (cnt_q == need_q);

  ocp_lookup #(.CNT_W(CNT_W)) u_lut (
    .opcode (in_byte),
    .nargs  (lut_n),
    .act    (lut_act),
    .known  (lut_known)
  );

  ocp_argbuf #(.MAX_ARGS(MAX_ARGS)) u_args (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cmd_byte && !at_op),
    .wr_idx  (IDX_W'(cnt_q - CNT_W'(1))),
    .wr_data (in_byte),
    .rd_idx  ('0),
    .rd_data (arg0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      need_q      <= '0;
      act_q       <= ACT_NONE;
      ram_we      <= 1'b0;
      ram_wdata   <= '0;
      col_load    <= 1'b0;
      row_load    <= 1'b0;
      win_first   <= '0;
      win_last    <= '0;
      remap_load  <= 1'b0;
      remap_val   <= '0;
      unknown_cmd <= 1'b0;
    end else begin
      ram_we      <= 1'b0;
      col_load    <= 1'b0;
      row_load    <= 1'b0;
      remap_load  <= 1'b0;
      unknown_cmd <= 1'b0;
      if (in_valid && in_is_data) begin
        ram_we    <= 1'b1;
        ram_wdata <= in_byte;
      end
      if (cmd_byte) begin
        if (at_op) begin
          unknown_cmd <= !lut_known;
          if (lut_n != '0) begin
            cnt_q  <= CNT_W'(1);
            need_q <= lut_n;
            act_q  <= lut_act;
          end
        end else if (arg_last) begin
          cnt_q <= '0;
          unique case (act_q)
            ACT_COL: begin
              col_load  <= 1'b1;
              win_first <= (need_q == CNT_W'(1)) ? in_byte : arg0;
              win_last  <= in_byte;
            end
            ACT_ROW: begin
              row_load  <= 1'b1;
              win_first <= (need_q == CNT_W'(1)) ? in_byte : arg0;
              win_last  <= in_byte;
            end
            ACT_REMAP: begin
              remap_load <= 1'b1;
              remap_val  <= in_byte;
            end
            default: ;
          endcase
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/oled_cmd_parser_chk.sv
module oled_cmd_parser_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_is_data,
  input logic       ram_we,
  input logic       col_load,
  input logic       row_load,
  input logic [7:0] win_first,
  input logic [7:0] win_last,
  input logic       remap_load,
  input logic [7:0] remap_val,
  input logic       unknown_cmd
);
  assert_write_from_data_R1: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(in_valid) && $past(in_is_data)));

  assert_write_alone_R1: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !(col_load || row_load || remap_load || unknown_cmd));

  assert_one_window_R3: assert property (@(posedge clk) disable iff (rst)
    !(col_load && row_load));

  assert_window_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!col_load && !row_load && !$past(rst)) |-> ($stable(win_first) && $stable(win_last)));

  assert_remap_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!remap_load && !$past(rst)) |-> $stable(remap_val));

  assert_unknown_from_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    unknown_cmd |-> ($past(in_valid) && !$past(in_is_data)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |->
      $countones({ram_we, col_load, row_load, remap_load, unknown_cmd}) == 0);
endmodule

bind oled_cmd_parser oled_cmd_parser_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_is_data  (in_is_data),
  .ram_we      (ram_we),
  .col_load    (col_load),
  .row_load    (row_load),
  .win_first   (win_first),
  .win_last    (win_last),
  .remap_load  (remap_load),
  .remap_val   (remap_val),
  .unknown_cmd (unknown_cmd)
);

// File: tb/sim_oled_cmd_parser.sv
`timescale 1ns/1ps
module sim_oled_cmd_parser;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_is_data = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       ram_we, col_load, row_load, remap_load, unknown_cmd;
  logic [7:0] ram_wdata, win_first, win_last, remap_val;

  always #2 clk = ~clk;

  oled_cmd_parser #(.MAX_ARGS(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_data(in_is_data),
    .in_byte(in_byte), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .col_load(col_load), .row_load(row_load), .win_first(win_first),
    .win_last(win_last), .remap_load(remap_load), .remap_val(remap_val),
    .unknown_cmd(unknown_cmd)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string phase = "R2";
  bit    done = 0;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // argument count per opcode from the requirements, -1 = unknown
  function automatic int argc(logic [7:0] b);
    case (b)
      8'h15, 8'h75: return 2;
      8'hA0, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: return 1;
      8'hB8: return 8;
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, 8'hFF: return 0;
      default: return -1;
    endcase
  endfunction

  // reference model
  int         m_left = 0;
  logic [7:0] m_op = 0;
  logic [7:0] m_args[$];
  bit         e_we, e_col, e_row, e_rml, e_unk;
  logic [7:0] e_wd = 0, e_wf = 0, e_wl = 0, e_rv = 0;

  always begin
    @(posedge clk);
    if (rst) begin
      e_we = 0; e_col = 0; e_row = 0; e_rml = 0; e_unk = 0;
      e_wd = 0; e_wf = 0; e_wl = 0; e_rv = 0;
      m_left = 0; m_args.delete();
    end else begin
      e_we = 0; e_col = 0; e_row = 0; e_rml = 0; e_unk = 0;
      if (in_valid && in_is_data) begin
        e_we = 1; e_wd = in_byte;
      end else if (in_valid) begin
        if (m_left == 0) begin
          int n;
          n = argc(in_byte);
          if (n < 0) e_unk = 1;
          if (n > 0) begin m_op = in_byte; m_left = n; m_args.delete(); end
        end else begin
          m_args.push_back(in_byte);
          m_left--;
          if (m_left == 0) begin
            if (m_op == 8'h15) begin e_col = 1; e_wf = m_args[0]; e_wl = in_byte; end
            if (m_op == 8'h75) begin e_row = 1; e_wf = m_args[0]; e_wl = in_byte; end
            if (m_op == 8'hA0) begin e_rml = 1; e_rv = in_byte; end
          end
        end
      end
    end
    #1;
    if (!done) begin
      check({"R1/", phase}, ram_we, e_we);
      check({"R1/", phase}, ram_wdata, e_wd);
      check({"R3/", phase}, col_load, e_col);
      check({"R4/", phase}, row_load, e_row);
      check({"R3/", phase}, win_first, e_wf);
      check({"R4/", phase}, win_last, e_wl);
      check({"R5/", phase}, remap_load, e_rml);
      check({"R5/", phase}, remap_val, e_rv);
      check({"R9/", phase}, unknown_cmd, e_unk);
    end
  end

  task automatic put(bit dat, logic [7:0] b);
    @(negedge clk);
    in_valid = 1; in_is_data = dat; in_byte = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_byte = $urandom;
      in_is_data = $urandom;
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] pool[$];
    pool = '{8'h15, 8'h75, 8'hA0, 8'h81, 8'hB8, 8'hA4, 8'hFF, 8'hE3, 8'h00, 8'h42, 8'hBF};
    repeat (3) @(negedge clk);
    phase = "R2";
    check("R2", {ram_we, col_load, row_load, remap_load, unknown_cmd}, 0);
    check("R2", remap_val, 0);
    rst = 0;
    idle(2);
    phase = "R1";
    put(1, 8'h3C); put(1, 8'hC3); idle(1);
    phase = "R3";
    put(0, 8'h15); put(0, 8'h04); put(0, 8'h3A); idle(1);
    phase = "R4";
    put(0, 8'h75); put(0, 8'h10); put(0, 8'h4F);
    phase = "R5";
    put(0, 8'hA0); put(0, 8'h52); idle(1);
    phase = "R6";
    put(0, 8'h81); put(0, 8'h15); put(0, 8'hA0); put(0, 8'h15);
    put(0, 8'hBE); put(0, 8'hFF); put(0, 8'h15); put(0, 8'h01); put(0, 8'h02);
    phase = "R7";
    put(0, 8'hB8);
    for (int i = 0; i < 8; i++) put(0, (i % 2) ? 8'h75 : 8'hA0);
    put(0, 8'hA0); put(0, 8'h77);
    phase = "R8";
    put(0, 8'hA4); put(0, 8'hFF); put(0, 8'hE3); put(0, 8'hAF);
    put(0, 8'h75); put(0, 8'h20); put(0, 8'h21);
    phase = "R9";
    put(0, 8'h00); put(0, 8'h42); put(0, 8'h75); put(0, 8'h05); put(0, 8'h06);
    phase = "R10";
    put(0, 8'h15); put(0, 8'h09); put(1, 8'h15); put(1, 8'hEE);
    put(0, 8'h0B); put(0, 8'hA0); put(1, 8'h99); put(0, 8'h61);
    phase = "R11";
    put(0, 8'h15); idle(3); put(0, 8'h07); idle(2); put(0, 8'h08); idle(2);
    phase = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 3) put(1, $urandom);
      else if (r < 5) put(0, pool[$urandom_range(0, pool.size() - 1)]);
      else if (r < 9) put(0, $urandom);
      else idle(1);
    end
    idle(3);
    finish_run();
  end
endmodule